// File: doc/BRIEF.md
# PLL Divider Parameter Search Engine

This block takes a requested PLL output frequency in kHz and searches for a divider setting that hits it from a fixed 24 MHz reference. It returns an input pre-divider (NR), a feedback multiplier (NF), an output divider (NO) and an extra post-divider placed after the PLL. The output frequency is `24000 * NF / (NR * NO * postDiv)` kHz.

The search runs in two phases. First it picks the smallest output division that lifts the VCO into its legal 440..2200 MHz window, splitting the division between NO (at most 16, even or 1) and the post-divider. Then it steps NR upward. For each NR it rounds NF to the nearest integer and keeps the closest candidate it has seen. All divisions go through one multi-cycle sequential divider inside the block, so a search takes from a few hundred to a few thousand cycles. Software or a boot sequencer pulses `start` with the target and waits for `done`.

Top module: `pll_param_search`

## Requirements
- R1: A target of 0 kHz completes with `done` and `searchErr` = 1 without any sweep.
- R2: With d0 = ceil(440000 / target), `postDiv` = ceil(d0 / 16) and `noSel` = ceil(d0 / postDiv). If that is greater than 1 it is raised to the next even value. Outputs carry the plain values (NR=1 reads as 1).
- R3: If VCO = target × `noSel` × `postDiv` is below 440000 kHz or above 2200000 kHz, or `noSel` exceeds 16, the search ends with `searchErr` = 1.
- R4: NR is tried in ascending order from 1 to 63. For each NR the step frequency f = 24000 / NR (truncated) is formed. The sweep stops if f < 269, and an NR with f > 2200000 is skipped. NF = VCO / f (truncated) is raised by one when the remainder exceeds f / 2 (truncated) and NF + 1 < 4096. A candidate with truncated NF ≥ 4096 is skipped.
- R5: A candidate's error is |VCO − NF × f|. It replaces the held best only when strictly smaller, so the lowest NR wins ties. The held best starts at the VCO value, and the sweep stops once the best error is 0.
- R6: If the best error after the sweep exceeds 4000 kHz, `searchErr` = 1. Otherwise `searchErr` = 0 and `nrSel`/`nfSel` hold the winning candidate.
- R7: `done` is high for exactly one cycle per accepted start. All result outputs and `searchErr` are valid in that cycle and stay unchanged until the next start.
- R8: After reset, `done`, `searchErr` and all result outputs are 0.
- R9: A `start` pulse while a search is running is ignored. The running search finishes with results for its own target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a search, accepted only when idle |
| targetKhz | input | TGT_W | Requested output frequency in kHz, sampled with start |
| done | output | 1 | One-cycle completion pulse |
| searchErr | output | 1 | 1 when the last search found no legal setting |
| nrSel | output | 6 | Chosen input pre-divider NR |
| nfSel | output | 12 | Chosen feedback multiplier NF |
| noSel | output | 5 | Chosen output divider NO |
| postDiv | output | 15 | Extra post-divider after the PLL |

## Verification
The targets span the range and are each compared field by field against an arithmetic model of the search. Very low targets (1 to 7 kHz) push the post-divider to its largest values. Common pixel and bus clocks end in an exact zero-error early stop at a small NR. Odd values such as 12345 and 1234567 need the full sweep and the NF round-up path. Zero and targets above 2200000 kHz, including the 2200000/2200001 edge, separate the zero rejection from the VCO range rejection. A start pulse issued mid-search with a different target checks that the running search is not disturbed. Each result is also re-read a few cycles after `done` to confirm it is held.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;
  localparam int unsigned REF_KHZ      = 24000;
  localparam int unsigned VCO_MIN_KHZ  = 440000;
  localparam int unsigned VCO_MAX_KHZ  = 2200000;
  localparam int unsigned FREF_MIN_KHZ = 269;
  localparam int unsigned FREF_MAX_KHZ = 2200000;
  localparam int unsigned MAX_NR       = 64;
  localparam int unsigned MAX_NF       = 4096;
  localparam int unsigned MAX_NO       = 16;
  localparam int unsigned ERR_LIM_KHZ  = 4000;

  localparam int unsigned NR_W  = $clog2(MAX_NR);
  localparam int unsigned NF_W  = $clog2(MAX_NF);
  localparam int unsigned NO_SH = $clog2(MAX_NO);
  localparam int unsigned NO_W  = NO_SH + 1;
  localparam int unsigned NO0_W = $clog2(VCO_MIN_KHZ + 1);
  localparam int unsigned EXT_W = NO0_W - NO_SH;

  typedef enum logic [1:0] {
    DS_NO0   = 2'd0,
    DS_NOADJ = 2'd1,
    DS_FREF  = 2'd2,
    DS_NF    = 2'd3
  } divSel_e;

  typedef struct packed {
    logic    capTarget;
    logic    divGo;
    divSel_e divSel;
    logic    capNo0;
    logic    capNo;
    logic    capVco;
    logic    capFref;
    logic    evalCand;
    logic    nextNr;
    logic    finOk;
    logic    finErr;
  } ctrl_t;

  typedef struct packed {
    logic tgtZero;
    logic divDone;
    logic vcoBad;
    logic frefLow;
    logic frefHigh;
    logic lastNr;
    logic bestZero;
    logic bestBig;
  } stat_t;
endpackage

// File: rtl/pll_search_div.sv
module pll_search_div #(
  parameter int unsigned W = 22
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         done,
  output logic [W-1:0] quot,
  output logic [W-1:0] rem
);
  localparam int unsigned CW = $clog2(W + 1);

  logic [CW-1:0] cnt;
  logic          busy;
  logic [W-1:0]  dvs;
  logic [W:0]    remShift;
  logic          fits;

  always_comb begin
    remShift = {rem, quot[W-1]};
    fits     = remShift >= {1'b0, dvs};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
      dvs  <= '0;
      quot <= '0;
      rem  <= '0;
    end else if (go) begin
      cnt  <= CW'(W);
      busy <= 1'b1;
      done <= 1'b0;
      dvs  <= divisor;
      quot <= dividend;
      rem  <= '0;
    end else if (busy) begin
      if (fits) begin
        rem  <= W'(remShift - {1'b0, dvs});
        quot <= {quot[W-2:0], 1'b1};
      end else begin
        rem  <= remShift[W-1:0];
        quot <= {quot[W-2:0], 1'b0};
      end
      cnt <= cnt - 1'b1;
      if (cnt == CW'(1)) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end else begin
      done <= 1'b0;
    end
  end
endmodule

// File: rtl/pll_search_dp.sv
module pll_search_dp
  import pll_search_pkg::*;
#(
  parameter int unsigned TGT_W = 22
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_t            ctl,
  input  logic [TGT_W-1:0] targetKhz,
  output stat_t            st,
  output logic             searchErr,
  output logic [NR_W-1:0]  nrSel,
  output logic [NF_W-1:0]  nfSel,
  output logic [NO_W-1:0]  noSel,
  output logic [EXT_W-1:0] postDiv
);
  localparam int unsigned PROD_W = TGT_W + NO_W + EXT_W;
  localparam logic [TGT_W-1:0] VMIN  = TGT_W'(VCO_MIN_KHZ);
  localparam logic [TGT_W-1:0] REFV  = TGT_W'(REF_KHZ);
  localparam logic [TGT_W-1:0] NFLIM = TGT_W'(MAX_NF);

  logic [TGT_W-1:0] tgt, vco, fref, best;
  logic [NO0_W-1:0] no0;
  logic [EXT_W-1:0] ext;
  logic [NO_W-1:0]  noR;
  logic             noBig, vcoBad, failR;
  logic [NR_W-1:0]  nr, bestNr;
  logic [NF_W-1:0]  bestNf;

  logic [TGT_W-1:0] divA, divB, quot, rem;
  logic             divDone;

  always_comb begin
    divA = '0;
    divB = '0;
    unique case (ctl.divSel)
      DS_NO0:   begin divA = VMIN;          divB = tgt;           end
      DS_NOADJ: begin divA = TGT_W'(no0);   divB = TGT_W'(ext);   end
      DS_FREF:  begin divA = REFV;          divB = TGT_W'(nr);    end
      DS_NF:    begin divA = vco;           divB = fref;          end
    endcase
  end

  pll_search_div #(.W(TGT_W)) uDiv (
    .clk(clk), .rstN(rstN), .go(ctl.divGo),
    .dividend(divA), .divisor(divB),
    .done(divDone), .quot(quot), .rem(rem)
  );

  // ceiling quotient, shared by the two ceil divisions
  logic [TGT_W-1:0]  ceilQ;
  logic [NO0_W:0]    extFull;
  logic [TGT_W-1:0]  noEven;
  logic [PROD_W-1:0] prod;

  always_comb begin
    ceilQ   = quot + TGT_W'(rem != '0);
    extFull = ({1'b0, ceilQ[NO0_W-1:0]} + (NO0_W+1)'(MAX_NO - 1)) >> NO_SH;
    noEven  = ceilQ + TGT_W'((ceilQ > TGT_W'(1)) && ceilQ[0]);
    prod    = PROD_W'(tgt) * PROD_W'(noR) * PROD_W'(ext);
  end

  // candidate evaluation for one NR
  logic [TGT_W-1:0] nfPlus, candNf, candDiff;
  logic             nfOver, roundUp, better;

  always_comb begin
    nfPlus   = quot + TGT_W'(1);
    nfOver   = quot >= NFLIM;
    roundUp  = (nfPlus < NFLIM) && (rem > (fref >> 1));
    candNf   = roundUp ? nfPlus : quot;
    candDiff = roundUp ? (fref - rem) : rem;
    better   = !nfOver && (candDiff < best);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tgt    <= '0;
      vco    <= '0;
      fref   <= '0;
      best   <= '0;
      no0    <= '0;
      ext    <= '0;
      noR    <= '0;
      noBig  <= 1'b0;
      vcoBad <= 1'b0;
      failR  <= 1'b0;
      nr     <= '0;
      bestNr <= '0;
      bestNf <= '0;
    end else begin
      if (ctl.capTarget) tgt <= targetKhz;
      if (ctl.capNo0) begin
        no0 <= ceilQ[NO0_W-1:0];
        ext <= extFull[EXT_W-1:0];
      end
      if (ctl.capNo) begin
        noR   <= noEven[NO_W-1:0];
        noBig <= noEven > TGT_W'(MAX_NO);
      end
      if (ctl.capVco) begin
        vco    <= prod[TGT_W-1:0];
        best   <= prod[TGT_W-1:0];
        vcoBad <= (prod < PROD_W'(VCO_MIN_KHZ)) || (prod > PROD_W'(VCO_MAX_KHZ)) || noBig;
        nr     <= NR_W'(1);
        bestNr <= '0;
        bestNf <= '0;
      end
      if (ctl.capFref) fref <= quot;
      if (ctl.evalCand && better) begin
        best   <= candDiff;
        bestNr <= nr;
        bestNf <= candNf[NF_W-1:0];
      end
      if (ctl.nextNr) nr <= nr + 1'b1;
      if (ctl.finErr)     failR <= 1'b1;
      else if (ctl.finOk) failR <= 1'b0;
    end
  end

  always_comb begin
    st.tgtZero  = tgt == '0;
    st.divDone  = divDone;
    st.vcoBad   = vcoBad;
    st.frefLow  = fref < TGT_W'(FREF_MIN_KHZ);
    st.frefHigh = fref > TGT_W'(FREF_MAX_KHZ);
    st.lastNr   = nr == NR_W'(MAX_NR - 1);
    st.bestZero = best == '0;
    st.bestBig  = best > TGT_W'(ERR_LIM_KHZ);
  end

  assign searchErr = failR;
  assign nrSel     = bestNr;
  assign nfSel     = bestNf;
  assign noSel     = noR;
  assign postDiv   = ext;
endmodule

// File: rtl/pll_search_ctrl.sv
module pll_search_ctrl
  import pll_search_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  start,
  input  stat_t st,
  output ctrl_t ctl,
  output logic  done
);
  typedef enum logic [3:0] {
    S_IDLE, S_ZCHK, S_D_NO0, S_GO_NOADJ, S_D_NOADJ, S_VCO, S_VCHK,
    S_GO_FREF, S_D_FREF, S_PRUNE, S_D_NF, S_NEXT, S_FINAL
  } state_e;

  state_e state, nxt;

  always_comb begin
    ctl = '0;
    nxt = state;
    unique case (state)
      S_IDLE: if (start) begin
        ctl.capTarget = 1'b1;
        nxt = S_ZCHK;
      end
      S_ZCHK: if (st.tgtZero) begin
        ctl.finErr = 1'b1;
        nxt = S_IDLE;
      end else begin
        ctl.divGo  = 1'b1;
        ctl.divSel = DS_NO0;
        nxt = S_D_NO0;
      end
      S_D_NO0: if (st.divDone) begin
        ctl.capNo0 = 1'b1;
        nxt = S_GO_NOADJ;
      end
      S_GO_NOADJ: begin
        ctl.divGo  = 1'b1;
        ctl.divSel = DS_NOADJ;
        nxt = S_D_NOADJ;
      end
      S_D_NOADJ: if (st.divDone) begin
        ctl.capNo = 1'b1;
        nxt = S_VCO;
      end
      S_VCO: begin
        ctl.capVco = 1'b1;
        nxt = S_VCHK;
      end
      S_VCHK: if (st.vcoBad) begin
        ctl.finErr = 1'b1;
        nxt = S_IDLE;
      end else begin
        nxt = S_GO_FREF;
      end
      S_GO_FREF: begin
        ctl.divGo  = 1'b1;
        ctl.divSel = DS_FREF;
        nxt = S_D_FREF;
      end
      S_D_FREF: if (st.divDone) begin
        ctl.capFref = 1'b1;
        nxt = S_PRUNE;
      end
      S_PRUNE: if (st.frefLow) begin
        nxt = S_FINAL;
      end else if (st.frefHigh) begin
        nxt = S_NEXT;
      end else begin
        ctl.divGo  = 1'b1;
        ctl.divSel = DS_NF;
        nxt = S_D_NF;
      end
      S_D_NF: if (st.divDone) begin
        ctl.evalCand = 1'b1;
        nxt = S_NEXT;
      end
      S_NEXT: if (st.lastNr || st.bestZero) begin
        nxt = S_FINAL;
      end else begin
        ctl.nextNr = 1'b1;
        nxt = S_GO_FREF;
      end
      S_FINAL: begin
        if (st.bestBig) ctl.finErr = 1'b1;
        else            ctl.finOk  = 1'b1;
        nxt = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      done  <= 1'b0;
    end else begin
      state <= nxt;
      done  <= ctl.finOk | ctl.finErr;
    end
  end
endmodule

// File: rtl/pll_param_search.sv
module pll_param_search
  import pll_search_pkg::*;
#(
  parameter int unsigned TGT_W = 22
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [TGT_W-1:0] targetKhz,
  output logic             done,
  output logic             searchErr,
  output logic [NR_W-1:0]  nrSel,
  output logic [NF_W-1:0]  nfSel,
  output logic [NO_W-1:0]  noSel,
  output logic [EXT_W-1:0] postDiv
);
  ctrl_t ctl;
  stat_t st;

  pll_search_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .st(st), .ctl(ctl), .done(done)
  );

  pll_search_dp #(.TGT_W(TGT_W)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .targetKhz(targetKhz), .st(st),
    .searchErr(searchErr), .nrSel(nrSel), .nfSel(nfSel),
    .noSel(noSel), .postDiv(postDiv)
  );
endmodule

// File: rtl/pll_param_search_chk.sv
module pll_param_search_chk
  import pll_search_pkg::*;
#(
  parameter int unsigned TGT_W = 22
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [TGT_W-1:0] targetKhz,
  input logic             done,
  input logic             searchErr,
  input logic [NR_W-1:0]  nrSel,
  input logic [NF_W-1:0]  nfSel,
  input logic [NO_W-1:0]  noSel,
  input logic [EXT_W-1:0] postDiv
);
  logic             running, hold;
  logic [TGT_W-1:0] tgtLat;
  longint           vcoCalc, prodA, prodB, absDiff;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      hold    <= 1'b0;
      tgtLat  <= '0;
    end else begin
      if (start && (!running || done)) begin
        running <= 1'b1;
        tgtLat  <= targetKhz;
      end else if (done) begin
        running <= 1'b0;
      end
      if (start)     hold <= 1'b0;
      else if (done) hold <= 1'b1;
    end
  end

  always_comb begin
    vcoCalc = longint'(tgtLat) * longint'(noSel) * longint'(postDiv);
    prodA   = longint'(nfSel) * longint'(REF_KHZ);
    prodB   = vcoCalc * longint'(nrSel);
    absDiff = (prodA > prodB) ? (prodA - prodB) : (prodB - prodA);
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R7
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    ((done || hold) && !start) |=> $stable({searchErr, nrSel, nfSel, noSel, postDiv})); // R7
  AST_ZERO_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    (done && tgtLat == '0) |-> searchErr); // R1
  AST_NO_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (done && !searchErr) |-> ((noSel == NO_W'(1)) || (!noSel[0] && noSel <= NO_W'(MAX_NO)))); // R2
  AST_VCO_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    (done && !searchErr) |-> (vcoCalc >= longint'(VCO_MIN_KHZ) && vcoCalc <= longint'(VCO_MAX_KHZ))); // R3
  AST_NR_SPAN: assert property (@(posedge clk) disable iff (!rstN)
    (done && !searchErr) |-> (nrSel >= NR_W'(1) && nrSel <= NR_W'(MAX_NR - 1))); // R4
  AST_ERR_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (done && !searchErr) |-> (absDiff <= longint'(ERR_LIM_KHZ) * longint'(nrSel))); // R6
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> running); // R9
endmodule

bind pll_param_search pll_param_search_chk #(.TGT_W(TGT_W)) uChk (
  .clk(clk), .rstN(rstN), .start(start), .targetKhz(targetKhz), .done(done),
  .searchErr(searchErr), .nrSel(nrSel), .nfSel(nfSel), .noSel(noSel), .postDiv(postDiv)
);

// File: tb/tb_pll_param_search.sv
module tb_pll_param_search;
  localparam int TW = 22;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [TW-1:0] targetKhz = '0;
  logic          done, searchErr;
  logic [5:0]    nrSel;
  logic [11:0]   nfSel;
  logic [4:0]    noSel;
  logic [14:0]   postDiv;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  pll_param_search #(.TGT_W(TW)) dut (
    .clk(clk), .rstN(rstN), .start(start), .targetKhz(targetKhz),
    .done(done), .searchErr(searchErr), .nrSel(nrSel), .nfSel(nfSel),
    .noSel(noSel), .postDiv(postDiv)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic void model(input longint t, output bit f, output longint eNr,
                                output longint eNf, output longint eNo, output longint eExt);
    longint d0, vco, best, fr, q, d;
    f = 1'b0; eNr = 0; eNf = 0; eNo = 0; eExt = 0;
    if (t == 0) begin f = 1'b1; return; end
    d0   = (440000 + t - 1) / t;
    eExt = (d0 + 15) / 16;
    eNo  = (d0 + eExt - 1) / eExt;
    if (eNo > 1) eNo = ((eNo + 1) / 2) * 2;
    vco = t * eNo * eExt;
    if (vco < 440000 || vco > 2200000 || eNo > 16) begin f = 1'b1; return; end
    best = vco;
    for (int r = 1; r < 64 && best != 0; r++) begin
      fr = 24000 / r;
      if (fr < 269) break;
      if (fr > 2200000) continue;
      q = vco / fr;
      if (q >= 4096) continue;
      d = vco - q * fr;
      if (q + 1 < 4096 && d > fr / 2) begin q++; d = fr - d; end
      if (d < best) begin best = d; eNr = r; eNf = q; end
    end
    f = best > 4000;
  endfunction

  task automatic runOne(input longint t, input bit disturb);
    bit f; longint eNr, eNf, eNo, eExt;
    int cyc;
    logic [5:0] hNr; logic [11:0] hNf; logic [4:0] hNo; logic [14:0] hExt; logic hErr;
    model(t, f, eNr, eNf, eNo, eExt);
    @(negedge clk);
    targetKhz = TW'(t);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 8000) begin
      @(negedge clk);
      cyc++;
      if (disturb && cyc == 12) begin
        targetKhz = TW'(2200000);
        start = 1'b1;
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    chk(done == 1'b1, "R7", $sformatf("done seen t=%0d", t), longint'(done), 1);
    if (t == 0) chk(searchErr == f, "R1", "zero target err", longint'(searchErr), longint'(f));
    else chk(searchErr == f, "R3 R6", $sformatf("err t=%0d", t), longint'(searchErr), longint'(f));
    if (!f) begin
      chk(postDiv == eExt, "R2", $sformatf("postDiv t=%0d", t), longint'(postDiv), eExt);
      chk(noSel == eNo, "R2", $sformatf("no t=%0d", t), longint'(noSel), eNo);
      chk(nrSel == eNr, disturb ? "R9 R5" : "R4 R5", $sformatf("nr t=%0d", t), longint'(nrSel), eNr);
      chk(nfSel == eNf, disturb ? "R9 R4" : "R4 R5", $sformatf("nf t=%0d", t), longint'(nfSel), eNf);
    end
    hNr = nrSel; hNf = nfSel; hNo = noSel; hExt = postDiv; hErr = searchErr;
    @(negedge clk);
    chk(done == 1'b0, "R7", "done one cycle", longint'(done), 0);
    repeat (3) @(negedge clk);
    chk({nrSel, nfSel, noSel, postDiv, searchErr} == {hNr, hNf, hNo, hExt, hErr},
        "R7", $sformatf("hold t=%0d", t), longint'(nfSel), longint'(hNf));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(done == 1'b0 && searchErr == 1'b0, "R8", "reset flags", longint'({done, searchErr}), 0);
    chk({nrSel, nfSel, noSel, postDiv} == '0, "R8", "reset results",
        longint'({nrSel, nfSel, noSel, postDiv}), 0);
    rstN = 1'b1;
    @(negedge clk);
    runOne(0, 1'b0);
    runOne(1, 1'b0);
    runOne(2, 1'b0);
    runOne(3, 1'b0);
    runOne(7, 1'b0);
    runOne(100, 1'b0);
    runOne(1000, 1'b0);
    runOne(12345, 1'b0);
    runOne(27499, 1'b0);
    runOne(27500, 1'b0);
    runOne(65000, 1'b0);
    runOne(74250, 1'b0);
    runOne(100000, 1'b0);
    runOne(148500, 1'b0);
    runOne(297000, 1'b0);
    runOne(333333, 1'b0);
    runOne(440000, 1'b0);
    runOne(533000, 1'b0);
    runOne(666000, 1'b0);
    runOne(800000, 1'b0);
    runOne(1234567, 1'b0);
    runOne(1800000, 1'b0);
    runOne(2199999, 1'b0);
    runOne(2200000, 1'b0);
    runOne(2200001, 1'b0);
    runOne(3000000, 1'b0);
    runOne(4194303, 1'b0);
    runOne(0, 1'b0);
    runOne(12345, 1'b1);
    runOne(1, 1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R7 actual=%0d expected=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule